// File: doc/BRIEF.md
# Bus-Sizing Single Transfer Engine

This block moves one item of 1, 2 or 4 bytes from a source address to a destination address over a shared memory bus. It works in two phases. First it reads the whole item from the source. Then it writes the item to the destination. Before it starts, it asks a bus arbiter for ownership and waits for the grant. It keeps ownership until the last write has finished.

The memory region that the current bus address falls in tells the block the port width on that side: 8, 16 or 32 bits. When the port is narrower than the item, the block splits the access into several narrow bus cycles. Read data is collected into a small byte buffer, and the write side takes the data back out of that buffer in pieces. The block never realigns data. A request whose addresses do not suit its size is rejected with an error pulse, and no bus traffic follows.

The controller is a five-state machine:

| State | Role | Transition |
|-------|------|------------|
| `ST_IDLE` | Waits for `start`. | A legal `start` goes to `ST_ARB`. An illegal one stays in `ST_IDLE` and pulses `err`. |
| `ST_ARB` | Holds `bus_req` and waits for the grant. | `bus_ack` goes to `ST_READ`. |
| `ST_READ` | Issues read sub-cycles. | The last accepted read goes to `ST_WRITE`. |
| `ST_WRITE` | Issues write sub-cycles. | The last accepted write goes to `ST_DONE`. |
| `ST_DONE` | Drops `bus_req` and pulses `done`. | Returns to `ST_IDLE` unconditionally. |

Top module: `dma_xfer_unit`

## Requirements
- R1: `xfer_size` encodes the item length as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 is illegal and is rejected like a misaligned request.
- R2: A 1-byte request is legal at any address. A 2-byte request needs both `src_addr` and `dst_addr` to be even. A 4-byte request needs both addresses to be multiples of 4. An illegal request, sampled on the edge where `start` is high in `ST_IDLE`, raises `err` for exactly the next cycle. It raises no `bus_req`, no bus cycle and no `done`, and it leaves memory untouched.
- R3: On the edge that accepts a legal `start`, `bus_req` rises in the next cycle. No read or write is issued until `bus_ack` is high. `bus_req` stays high from that point until the last write has been accepted.
- R4: Every read of a transfer comes before every write, and `bus_rd` and `bus_wr` are never high together.
- R5: `bus_port_w` gives the port width of the region at `bus_addr`, encoded as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. Each sub-cycle moves min(port bytes, bytes still to move). A transfer of B bytes therefore takes B / min(P, B) sub-cycles on a side whose port is P bytes wide.
- R6: The read phase starts at `src_addr` and the write phase starts at `dst_addr`. After each accepted sub-cycle, the address advances by the number of bytes that sub-cycle moved.
- R7: Sub-cycle data sits on the low lanes of the data bus: byte k of the sub-cycle is on bits [8k+7:8k]. `bus_nbytes` shows the byte count during each read or write cycle. Read lanes at or above `bus_nbytes` are ignored.
- R8: Data is packed little-endian. After the transfer, destination byte dst+k equals source byte src+k for every k below the length. No other destination byte changes.
- R9: A sub-cycle completes only on an edge where `bus_ready` is high. While `bus_ready` is low, the cycle type and `bus_addr` stay unchanged.
- R10: `done` is high for exactly one cycle, the cycle after the last write is accepted. In that cycle `bus_req` is already low, and a new `start` is accepted on the next edge.
- R11: `start` is ignored while a transfer is in progress. It neither raises `err` nor changes the transfer under way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer (sampled in `ST_IDLE`) |
| xfer_size | input | 2 | Item length code |
| src_addr | input | AW (32) | Source byte address |
| dst_addr | input | AW (32) | Destination byte address |
| err | output | 1 | One-cycle pulse for a rejected request |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_ack | input | 1 | Bus grant from the arbiter |
| bus_rd | output | 1 | Read sub-cycle active |
| bus_wr | output | 1 | Write sub-cycle active |
| bus_addr | output | AW (32) | Sub-cycle byte address |
| bus_nbytes | output | log2(DW/8)+1 (3) | Bytes moved by the current sub-cycle |
| bus_port_w | input | 2 | Port width code of the region at `bus_addr` |
| bus_rdata | input | DW (32) | Read data, low lanes used |
| bus_wdata | output | DW (32) | Write data, low lanes used |
| bus_ready | input | 1 | Completes the current sub-cycle |

## Verification
The assertions assume three things about the environment:
- `bus_ack` is never withdrawn while `bus_req` is high.
- `bus_port_w` is a legal code that depends only on `bus_addr`, within the same cycle.
- Once a sub-cycle has started, `bus_ready` is eventually given.

The bench's memory model keeps within these assumptions. It answers the grant after a random delay of up to three cycles and holds it until the request drops. It derives the port width from two address bits. It raises ready on a random schedule, and every sub-cycle eventually completes.

Random stimulus keeps source and destination windows apart, so that the expected memory image does not depend on the order of the sub-cycles.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } xfer_state_e;

endpackage

// File: rtl/dma_align_chk.sv
module dma_align_chk #(
    parameter int AW = 32,
    parameter int NB = 4
) (
    input  logic [1:0]    xfer_size,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    output logic          legal
);
    localparam int LNB = $clog2(NB);

    logic [AW-1:0] low_mask;
    logic          size_ok;

    always_comb begin
        size_ok  = (int'(xfer_size) <= LNB);
        low_mask = (AW'(1) << xfer_size) - AW'(1);
        legal    = size_ok
                   && ((src_addr & low_mask) == '0)
                   && ((dst_addr & low_mask) == '0);
    end
endmodule

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
    parameter int NB = 4,
    parameter int CW = 3
) (
    input  logic [1:0]    port_w,
    input  logic [CW-1:0] remain,
    output logic [CW-1:0] chunk
);
    localparam int LNB = $clog2(NB);

    logic [CW-1:0] port_bytes;

    always_comb begin
        if (int'(port_w) >= LNB)
            port_bytes = CW'(NB);
        else
            port_bytes = CW'(1) << port_w;
        chunk = (remain < port_bytes) ? remain : port_bytes;
    end
endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf #(
    parameter int NB = 4,
    parameter int CW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [CW-1:0]  offset,
    input  logic [CW-1:0]  chunk,
    input  logic [8*NB-1:0] rdata,
    output logic [8*NB-1:0] wdata
);
    localparam int DW = 8 * NB;

    logic [DW-1:0] shifted_in;
    logic [DW-1:0] store_q;
    logic [CW:0]   span_end;

    always_comb begin
        shifted_in = rdata << {offset, 3'b000};
        span_end   = {1'b0, offset} + {1'b0, chunk};
        wdata      = store_q >> {offset, 3'b000};
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic in_span;
        always_comb in_span = (CW'(i) >= offset) && ((CW+1)'(i) < span_end);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                store_q[8*i +: 8] <= '0;
            else if (load_en && in_span)
                store_q[8*i +: 8] <= shifted_in[8*i +: 8];
        end
    end
endmodule

// File: rtl/dma_xfer_unit.sv
module dma_xfer_unit
    import dma_xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [1:0]                    xfer_size,
    input  logic [AW-1:0]                 src_addr,
    input  logic [AW-1:0]                 dst_addr,
    output logic                          err,
    output logic                          done,
    output logic                          bus_req,
    input  logic                          bus_ack,
    output logic                          bus_rd,
    output logic                          bus_wr,
    output logic [AW-1:0]                 bus_addr,
    output logic [$clog2(DW/8):0]         bus_nbytes,
    input  logic [1:0]                    bus_port_w,
    input  logic [DW-1:0]                 bus_rdata,
    output logic [DW-1:0]                 bus_wdata,
    input  logic                          bus_ready
);
    localparam int NB  = DW / 8;
    localparam int LNB = $clog2(NB);
    localparam int CW  = LNB + 1;

    xfer_state_e   state_q, state_d;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] remain_q;
    logic [CW-1:0] total_q;
    logic [CW-1:0] offset_q;
    logic          err_q;

    logic          legal;
    logic          accept;
    logic [CW-1:0] chunk;
    logic [CW-1:0] req_bytes;
    logic          last_beat;
    logic          rd_load;
    logic [DW-1:0] packed_out;

    dma_align_chk #(.AW(AW), .NB(NB)) u_align (
        .xfer_size (xfer_size),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .legal     (legal)
    );

    dma_chunk_calc #(.NB(NB), .CW(CW)) u_chunk (
        .port_w (bus_port_w),
        .remain (remain_q),
        .chunk  (chunk)
    );

    dma_pack_buf #(.NB(NB), .CW(CW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (rd_load),
        .offset  (offset_q),
        .chunk   (chunk),
        .rdata   (bus_rdata),
        .wdata   (packed_out)
    );

    always_comb begin
        accept    = (state_q == ST_IDLE) && start && legal;
        req_bytes = CW'(1) << xfer_size;
        last_beat = bus_ready && (remain_q == chunk);
        rd_load   = (state_q == ST_READ) && bus_ready;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)     state_d = ST_ARB;
            ST_ARB:   if (bus_ack)    state_d = ST_READ;
            ST_READ:  if (last_beat)  state_d = ST_WRITE;
            ST_WRITE: if (last_beat)  state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            dst_q    <= '0;
            remain_q <= '0;
            total_q  <= '0;
            offset_q <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= (state_q == ST_IDLE) && start && !legal;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_q    <= src_addr;
                        dst_q    <= dst_addr;
                        remain_q <= req_bytes;
                        total_q  <= req_bytes;
                        offset_q <= '0;
                    end
                end
                ST_READ: begin
                    if (last_beat) begin
                        cur_q    <= dst_q;
                        remain_q <= total_q;
                        offset_q <= '0;
                    end else if (bus_ready) begin
                        cur_q    <= cur_q + AW'(chunk);
                        remain_q <= remain_q - chunk;
                        offset_q <= offset_q + chunk;
                    end
                end
                ST_WRITE: begin
                    if (bus_ready) begin
                        cur_q    <= cur_q + AW'(chunk);
                        remain_q <= remain_q - chunk;
                        offset_q <= offset_q + chunk;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_req    = 1'b0;
        bus_rd     = 1'b0;
        bus_wr     = 1'b0;
        done       = 1'b0;
        bus_nbytes = '0;
        bus_wdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARB:  bus_req = 1'b1;
            ST_READ: begin
                bus_req    = 1'b1;
                bus_rd     = 1'b1;
                bus_nbytes = chunk;
            end
            ST_WRITE: begin
                bus_req    = 1'b1;
                bus_wr     = 1'b1;
                bus_nbytes = chunk;
                bus_wdata  = packed_out;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        bus_addr = cur_q;
        err      = err_q;
    end
endmodule

// File: rtl/dma_xfer_unit_chk.sv
module dma_xfer_unit_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  err,
    input logic                  done,
    input logic                  bus_req,
    input logic                  bus_ack,
    input logic                  bus_rd,
    input logic                  bus_wr,
    input logic [AW-1:0]         bus_addr,
    input logic [$clog2(DW/8):0] bus_nbytes,
    input logic                  bus_ready
);
    localparam int NB = DW / 8;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));                                              // R4
    AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_rd);                                               // R4
    AST_CYCLE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_req && bus_ack));                      // R3
    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!bus_req && !done));                                      // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R10
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_req && $past(bus_wr && bus_ready)));                // R10
    AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));         // R9
    AST_HOLD_WRITE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr)));         // R9
    AST_NBYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_nbytes != 0 && int'(bus_nbytes) <= NB)); // R5
    AST_NO_CYCLE_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |-> (bus_nbytes == 0));                        // R7
endmodule

bind dma_xfer_unit dma_xfer_unit_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err        (err),
    .done       (done),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_nbytes (bus_nbytes),
    .bus_ready  (bus_ready)
);

// File: tb/tb_dma_xfer_unit.sv
module tb_dma_xfer_unit;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    xfer_size = '0;
    logic [AW-1:0] src_addr = '0;
    logic [AW-1:0] dst_addr = '0;
    logic          err, done, bus_req, bus_rd, bus_wr;
    logic          bus_ack = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [2:0]    bus_nbytes;
    logic [1:0]    bus_port_w;
    logic [DW-1:0] bus_rdata = '0;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] mem [1024];
    logic [7:0] ref_mem [1024];

    int rd_beats, wr_beats, grant_viol, hold_viol, lane_viol, ack_dly;
    logic          waiting;
    logic [AW-1:0] wait_addr;
    logic          wait_rd;

    always #2.5 clk = ~clk;

    dma_xfer_unit #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_size(xfer_size),
        .src_addr(src_addr), .dst_addr(dst_addr), .err(err), .done(done),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_nbytes(bus_nbytes), .bus_port_w(bus_port_w),
        .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .bus_ready(bus_ready)
    );

    // region map: address bits [9:8] -> 0:8b 1:16b 2:32b 3:8b
    function automatic logic [1:0] region_w(input logic [AW-1:0] a);
        return (a[9:8] == 2'd3) ? 2'd0 : a[9:8];
    endfunction
    function automatic int port_bytes(input logic [AW-1:0] a);
        return 1 << region_w(a);
    endfunction
    function automatic int beats(input int nbytes, input logic [AW-1:0] a);
        int p;
        p = port_bytes(a);
        if (p > nbytes) p = nbytes;
        return nbytes / p;
    endfunction

    assign bus_port_w = region_w(bus_addr);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory and arbiter model, all on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (!bus_req) bus_ack = 1'b0;
        else if (!bus_ack) begin
            if (ack_dly == 0) bus_ack = 1'b1;
            else ack_dly--;
        end
        bus_ready = 1'b0;
        if (bus_rd || bus_wr) begin
            if (!bus_ack) grant_viol++;
            if (waiting && (bus_addr != wait_addr || bus_rd != wait_rd)) hold_viol++;
            if (int'(bus_nbytes) > port_bytes(bus_addr) || bus_nbytes == 0) lane_viol++;
            bus_rdata = $urandom;
            for (int k = 0; k < 4; k++)
                if (k < int'(bus_nbytes))
                    bus_rdata[8*k +: 8] = mem[(bus_addr[9:0] + 10'(k))];
            if (($urandom % 3) != 0) begin
                bus_ready = 1'b1;
                waiting   = 1'b0;
                if (bus_rd) rd_beats++;
                else begin
                    wr_beats++;
                    for (int k = 0; k < 4; k++)
                        if (k < int'(bus_nbytes))
                            mem[(bus_addr[9:0] + 10'(k))] = bus_wdata[8*k +: 8];
                end
            end else begin
                waiting   = 1'b1;
                wait_addr = bus_addr;
                wait_rd   = bus_rd;
            end
        end else waiting = 1'b0;
    end

    task automatic run_xfer(input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input logic [1:0] sz, input bit poke);
        int nb;
        bit legal;
        bit got_done;
        bit mem_ok;
        int bad_idx;
        nb    = 1 << sz;
        legal = (sz != 2'd3) && ((s % nb) == 0) && ((d % nb) == 0);
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 8'($urandom);
            ref_mem[i] = mem[i];
        end
        if (legal)
            for (int k = 0; k < nb; k++) ref_mem[d[9:0] + 10'(k)] = ref_mem[s[9:0] + 10'(k)];
        rd_beats = 0; wr_beats = 0; grant_viol = 0; hold_viol = 0; lane_viol = 0;
        waiting = 1'b0;
        ack_dly = $urandom % 4;
        @(negedge clk);
        start = 1'b1; xfer_size = sz; src_addr = s; dst_addr = d;
        @(negedge clk);
        start = 1'b0;
        if (!legal) begin
            check(err == 1'b1, "R2 err pulse", int'(err), 1);
            check(bus_req == 1'b0, "R2 no request", int'(bus_req), 0);
            @(negedge clk);
            check(err == 1'b0, "R2 err one cycle", int'(err), 0);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (bus_req || done) check(1'b0, "R2 quiet after reject", 1, 0);
            end
        end else begin
            check(bus_req == 1'b1 && err == 1'b0, "R3 request raised", int'(bus_req), 1);
            if (poke) begin
                start = 1'b1; xfer_size = 2'd3; src_addr = 32'h1; dst_addr = 32'h3;
                @(negedge clk);
                start = 1'b0;
            end
            got_done = 1'b0;
            for (int i = 0; i < 200 && !got_done; i++) begin
                if (err) check(1'b0, "R11 start ignored while busy", 1, 0);
                if (done) got_done = 1'b1;
                else @(negedge clk);
            end
            check(got_done, "R10 done seen", int'(got_done), 1);
            check(bus_req == 1'b0, "R10 request low at done", int'(bus_req), 0);
            check(rd_beats == beats(nb, s), "R5 read sub-cycles", rd_beats, beats(nb, s));
            check(wr_beats == beats(nb, d), "R5 write sub-cycles", wr_beats, beats(nb, d));
            check(grant_viol == 0, "R3 cycle without grant", grant_viol, 0);
            check(hold_viol == 0, "R9 hold while not ready", hold_viol, 0);
            check(lane_viol == 0, "R7 byte count per cycle", lane_viol, 0);
            @(negedge clk);
            check(done == 1'b0, "R10 done one cycle", int'(done), 0);
        end
        mem_ok = 1'b1; bad_idx = 0;
        for (int i = 0; i < 1024; i++)
            if (mem_ok && mem[i] !== ref_mem[i]) begin mem_ok = 1'b0; bad_idx = i; end
        check(mem_ok, legal ? "R8 R6 memory image" : "R2 memory untouched",
              int'(mem[bad_idx]), int'(ref_mem[bad_idx]));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check(bus_req == 0 && done == 0 && err == 0 && bus_rd == 0 && bus_wr == 0,
              "R3 reset state", int'(bus_req), 0);
        rst_n = 1'b1;
        // directed corners
        run_xfer(32'h100, 32'h010, 2'd1, 1'b0);   // R5 16-bit -> 8-bit: 1 read, 2 writes
        run_xfer(32'h020, 32'h204, 2'd2, 1'b0);   // R5 8-bit -> 32-bit: 4 reads, 1 write
        run_xfer(32'h203, 32'h101, 2'd0, 1'b0);   // R2 R7 odd byte addresses
        run_xfer(32'h104, 32'h30C, 2'd2, 1'b0);   // R8 16-bit -> 8-bit region 3
        run_xfer(32'h202, 32'h010, 2'd2, 1'b0);   // R2 misaligned 4-byte source
        run_xfer(32'h010, 32'h013, 2'd1, 1'b0);   // R2 odd 2-byte destination
        run_xfer(32'h010, 32'h020, 2'd3, 1'b0);   // R1 illegal size code
        run_xfer(32'h200, 32'h008, 2'd2, 1'b1);   // R11 start during transfer
        run_xfer(32'h0F0, 32'h200, 2'd0, 1'b0);   // R1 single byte to wide port
        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [1:0]    sz;
            logic [AW-1:0] s, d;
            int            nb;
            sz = (($urandom % 8) == 0) ? 2'd3 : 2'($urandom % 3);
            nb = (sz == 2'd3) ? 1 : (1 << sz);
            do begin
                s = 32'($urandom % 1020);
                d = 32'($urandom % 1020);
                if (($urandom % 4) != 0) begin
                    s = s & ~32'(nb - 1);
                    d = d & ~32'(nb - 1);
                end
            end while ((s > d ? s - d : d - s) < 8);
            run_xfer(s, d, sz, (($urandom % 10) == 0));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule